// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a synchronous request port inside the chip and an external asynchronous static RAM of 256K words of 4 bits. A client raises a request strobe with a write flag, an 18-bit word address and, for stores, a 4-bit value. The controller then shapes the chip-select, output-enable and write-enable pulses and drives the address and data pins. Every interval is a parameter counted in clock cycles, so the defaults can be retuned for other clock rates.

Loads hold the chip selected with its outputs enabled for a fixed number of cycles. The returned nibble is then registered and handed back with a one-cycle valid strobe.

Stores follow a fixed order. The chip is first selected while its outputs stay off. Write enable then falls on the same edge that turns on the controller's own data drivers. Write enable and chip select rise together to end the store, and the drivers stay on through one recovery interval. The busy flag covers the whole access, and any request made while it is high is dropped.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high, and on the first edge after it, sel_n, rd_en_n and wr_en_n are 1, drive_en is 0, busy is 0 and rsp_valid is 0.
- R2: A load accepted on an edge holds sel_n=0, rd_en_n=0 and wr_en_n=1 with the request address on mem_addr for RD_CYC cycles (default 2). busy is 1 for exactly those cycles.
- R3: At the end of a load, rsp_data carries the value on mem_dq_i sampled on the closing edge. rsp_valid is 1 for exactly one cycle, starting on the edge where busy falls.
- R4: A store holds sel_n=0 with rd_en_n=1 for TURN_CYC cycles. It then holds wr_en_n=0 for PULSE_CYC cycles (default 1), and wr_en_n and sel_n rise on the same edge. busy covers TURN_CYC+PULSE_CYC+RECOV_CYC cycles (default 3).
- R5: drive_en is 1 only while rd_en_n is 1, and rd_en_n is already 1 on the cycle before drive_en rises.
- R6: While wr_en_n is 0, mem_addr equals the request address and mem_dq_o equals the request data, and neither changes.
- R7: A request presented while busy is 1 is ignored: it changes no memory word and produces no rsp_valid.
- R8: A value stored at an address is returned by a later load of that address, for any mix of loads and stores back to back.
- R9: wr_en_n is 0 only while sel_n is 0 and rd_en_n is 1.
- R10: mem_addr does not change while sel_n stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | 18 | Word address |
| req_wdata | input | 4 | Store data |
| busy | output | 1 | Access in progress, new requests dropped |
| rsp_valid | output | 1 | One-cycle strobe for load data |
| rsp_data | output | 4 | Registered load data |
| sel_n | output | 1 | Memory chip select, active low |
| rd_en_n | output | 1 | Memory output enable, active low |
| wr_en_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 18 | Memory address pins |
| mem_dq_o | output | 4 | Data toward the memory |
| mem_dq_i | input | 4 | Data from the memory |
| drive_en | output | 1 | Enables the pad drivers for mem_dq_o |

## Verification
The bench memory model returns a value only after the chip has been selected with outputs enabled for two full cycles. A controller that captures one cycle early would therefore read zero instead of the stored value. The model flags any cycle in which the pad drivers and the memory outputs are on together, as a turnaround missing between a load and a store would cause. Requests pulsed during a store check that a controller which accepts them while busy would either overwrite a word or give a spurious load strobe. The bench also checks that wr_en_n is low for exactly one cycle, that stored words read back for addresses at both ends of the range, and that a reset in the middle of an access returns every pin to idle.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WRECOV = 3'd4
  } asram_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC    = 2,
  parameter int TURN_CYC  = 1,
  parameter int PULSE_CYC = 1,
  parameter int RECOV_CYC = 1,
  parameter int CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             launch,
  output logic             capture,
  output logic             busy,
  output logic             sel_n,
  output logic             rd_en_n,
  output logic             wr_en_n,
  output logic             drive_en
);
  asram_state_e state, nxt;

  // Next-state and timer loading; every phase lasts its parameter in cycles.
  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    launch   = 1'b0;
    capture  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          launch   = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            nxt     = ST_WSETUP;
            tmr_val = CNT_W'(TURN_CYC - 1);
          end else begin
            nxt     = ST_READ;
            tmr_val = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (expired) begin
          capture = 1'b1;
          nxt     = ST_IDLE;
        end
      end
      ST_WSETUP: begin
        if (expired) begin
          nxt      = ST_WPULSE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(PULSE_CYC - 1);
        end
      end
      ST_WPULSE: begin
        if (expired) begin
          nxt      = ST_WRECOV;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RECOV_CYC - 1);
        end
      end
      ST_WRECOV: begin
        if (expired) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // Pin controls are registered from the next state so they change cleanly on edges.
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      sel_n    <= 1'b1;
      rd_en_n  <= 1'b1;
      wr_en_n  <= 1'b1;
      drive_en <= 1'b0;
    end else begin
      state    <= nxt;
      busy     <= (nxt != ST_IDLE);
      sel_n    <= !((nxt == ST_READ) || (nxt == ST_WSETUP) || (nxt == ST_WPULSE));
      rd_en_n  <= !(nxt == ST_READ);
      wr_en_n  <= !(nxt == ST_WPULSE);
      drive_en <= (nxt == ST_WPULSE) || (nxt == ST_WRECOV);
    end
  end
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_data  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      if (launch) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      if (capture) rsp_data <= mem_dq_i;
      rsp_valid <= capture;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 4,
  parameter int RD_CYC    = 2,
  parameter int TURN_CYC  = 1,
  parameter int PULSE_CYC = 1,
  parameter int RECOV_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              sel_n,
  output logic              rd_en_n,
  output logic              wr_en_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              drive_en
);
  // All phase lengths must be at least one cycle.
  localparam int MAX_CYC = max_of(max_of(RD_CYC, TURN_CYC), max_of(PULSE_CYC, RECOV_CYC));
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             expired;
  logic             launch;
  logic             capture;

  asram_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  asram_seq #(
    .RD_CYC    (RD_CYC),
    .TURN_CYC  (TURN_CYC),
    .PULSE_CYC (PULSE_CYC),
    .RECOV_CYC (RECOV_CYC),
    .CNT_W     (CNT_W)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .expired   (expired),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .launch    (launch),
    .capture   (capture),
    .busy      (busy),
    .sel_n     (sel_n),
    .rd_en_n   (rd_en_n),
    .wr_en_n   (wr_en_n),
    .drive_en  (drive_en)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .rsp_data  (rsp_data),
    .rsp_valid (rsp_valid)
  );
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rsp_valid,
  input logic              sel_n,
  input logic              rd_en_n,
  input logic              wr_en_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              drive_en
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (sel_n && rd_en_n && wr_en_n && !drive_en && !busy && !rsp_valid)); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid); // R3
  AST_SELECT_WITHIN_BUSY: assert property (@(posedge clk) disable iff (rst) !sel_n |-> busy); // R7
  AST_DRIVE_NEEDS_OE_OFF: assert property (@(posedge clk) disable iff (rst) drive_en |-> rd_en_n); // R5
  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (rst) $rose(drive_en) |-> $past(rd_en_n)); // R5
  AST_WRITE_PULSE_STABLE: assert property (@(posedge clk) disable iff (rst) (!wr_en_n && !$past(wr_en_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o))); // R6
  AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst) !wr_en_n |-> (!sel_n && rd_en_n)); // R9
  AST_WRITE_END_TOGETHER: assert property (@(posedge clk) disable iff (rst) $rose(wr_en_n) |-> sel_n); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) (!sel_n && !$past(sel_n)) |-> $stable(mem_addr)); // R10
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .sel_n     (sel_n),
  .rd_en_n   (rd_en_n),
  .wr_en_n   (wr_en_n),
  .mem_addr  (mem_addr),
  .mem_dq_o  (mem_dq_o),
  .drive_en  (drive_en)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        busy, rsp_valid, sel_n, rd_en_n, wr_en_n, drive_en;
  logic [3:0]  rsp_data, mem_dq_o;
  logic [3:0]  mem_dq_i;
  logic [17:0] mem_addr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  asram_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sel_n(sel_n),
    .rd_en_n(rd_en_n), .wr_en_n(wr_en_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .drive_en(drive_en)
  );

  // Memory model: 256 words keyed by the low address byte; load data appears
  // only after two sampled cycles of select with outputs on at one address.
  logic [3:0]  mem   [256];
  logic [3:0]  shadow[256];
  int          rd_age = 0;
  logic [17:0] rd_addr_q = '0;
  logic        prev_rd_en_n = 1'b1;
  int          we_low_cnt = 0;
  logic [17:0] we_addr_seen = '0;
  logic [3:0]  we_data_seen = '0;

  assign mem_dq_i = (!sel_n && !rd_en_n && wr_en_n && rd_age >= 2) ? mem[mem_addr[7:0]] : 4'h0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (drive_en && !rd_en_n) begin
        errors++;
        $display("FAIL R5 drivers on with memory outputs on actual=%0h expected=%0h", 1, 0);
      end
      if (drive_en && !prev_rd_en_n) begin
        errors++;
        $display("FAIL R5 no turnaround cycle actual=%0h expected=%0h", 0, 1);
      end
      if (!sel_n && !wr_en_n && drive_en) begin
        mem[mem_addr[7:0]] = mem_dq_o;
        we_low_cnt++;
        we_addr_seen = mem_addr;
        we_data_seen = mem_dq_o;
      end
      if (!sel_n && !rd_en_n && wr_en_n) begin
        rd_age    = (rd_age > 0 && mem_addr == rd_addr_q) ? rd_age + 1 : 1;
        rd_addr_q = mem_addr;
      end else begin
        rd_age = 0;
      end
    end else begin
      rd_age = 0;
    end
    prev_rd_en_n = rd_en_n;
  end

  // Issues one request and returns busy length, strobe and data when busy falls.
  task automatic do_op(input logic wr, input logic [17:0] a, input logic [3:0] d,
                       output int bcyc, output logic rv, output logic [3:0] rd);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    we_low_cnt = 0;
    @(negedge clk);
    req_valid = 1'b0;
    bcyc = 0;
    while (busy) begin
      bcyc++;
      @(negedge clk);
    end
    rv = rsp_valid;
    rd = rsp_data;
  endtask

  localparam int NVEC = 12;
  // {write, address, data}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 18'h00000, 4'hA},
    {1'b1, 18'h3FFFF, 4'h5},
    {1'b0, 18'h00000, 4'h0},
    {1'b1, 18'h12345, 4'hF},
    {1'b0, 18'h3FFFF, 4'h0},
    {1'b0, 18'h12345, 4'h0},
    {1'b1, 18'h00001, 4'h3},
    {1'b1, 18'h00000, 4'hC},
    {1'b0, 18'h00001, 4'h0},
    {1'b0, 18'h00000, 4'h0},
    {1'b1, 18'h3FFFF, 4'h9},
    {1'b0, 18'h3FFFF, 4'h0}
  };

  logic finished = 1'b0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 4'h0;
      shadow[i] = 4'h0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bc;
    logic rv;
    logic [3:0] rd;
    repeat (3) @(negedge clk);
    // R1: pins idle while in reset
    chk(sel_n && rd_en_n && wr_en_n && !drive_en && !busy && !rsp_valid, "R1 idle in reset",
        {sel_n, rd_en_n, wr_en_n, drive_en, busy, rsp_valid}, 6'b111000);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic        w;
      logic [17:0] a;
      logic [3:0]  d;
      w = VEC[i][22]; a = VEC[i][21:4]; d = VEC[i][3:0];
      do_op(w, a, d, bc, rv, rd);
      if (w) begin
        shadow[a[7:0]] = d;
        chk(bc == 3, "R4 store busy length", bc, 3);
        chk(we_low_cnt == 1, "R4 write pulse cycles", we_low_cnt, 1);
        chk(we_addr_seen == a && we_data_seen == d, "R6 address and data during pulse",
            {we_addr_seen, we_data_seen}, {a, d});
      end else begin
        chk(bc == 2, "R2 load busy length", bc, 2);
        chk(rv == 1'b1, "R3 strobe with busy fall", rv, 1);
        chk(rd == shadow[a[7:0]], "R8 read back", rd, shadow[a[7:0]]);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R3 strobe lasts one cycle", rsp_valid, 0);
      end
    end

    // R7: requests during a store are dropped
    do_op(1'b1, 18'h00020, 4'h3, bc, rv, rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00030; req_wdata = 4'h7;
    @(negedge clk);
    req_addr = 18'h00020; req_wdata = 4'h6;
    begin
      int strobes = 0;
      for (int k = 0; k < 3; k++) begin
        if (k == 1) req_write = 1'b0;
        @(negedge clk);
        if (rsp_valid) strobes++;
      end
      req_valid = 1'b0;
      while (busy) @(negedge clk);
      chk(strobes == 0, "R7 no strobe from dropped load", strobes, 0);
    end
    do_op(1'b0, 18'h00020, 4'h0, bc, rv, rd);
    chk(rd == 4'h3, "R7 dropped store left word intact", rd, 3);

    // R2: load pins during an access
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h2AB45;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!sel_n && !rd_en_n && wr_en_n && mem_addr == 18'h2AB45, "R2 load pin state",
        {sel_n, rd_en_n, wr_en_n}, 3'b001);
    while (busy) @(negedge clk);

    // R1: reset in the middle of a store
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00040; req_wdata = 4'hE;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(sel_n && rd_en_n && wr_en_n && !drive_en && !busy, "R1 reset mid store",
        {sel_n, rd_en_n, wr_en_n, drive_en, busy}, 5'b11100);
    rst = 1'b0;
    do_op(1'b1, 18'h00050, 4'hB, bc, rv, rd);
    do_op(1'b0, 18'h00050, 4'h0, bc, rv, rd);
    chk(rd == 4'hB, "R8 access after reset", rd, 4'hB);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule